// File: doc/BRIEF.md
# Word-Bus Serial Port with Programmable Bit Timing

This block is an asynchronous serial transmitter and receiver reached through a 32-bit register bus. The bus has word-aligned read and write strobes and a combinational read path. Software sets the character format in one configuration word: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. The same word sets the bit period as a plain count of core clocks per serial bit. A separate register sets the clock offset inside each bit period at which the receiver samples the line.

Characters written to the transmit data port wait in a 16-entry queue until the transmitter is allowed to send them. Received characters collect in a second 16-entry queue and are read through the receive data port. Seven interrupt sources are combined into one interrupt line through an enable mask. Two of them are live queue levels and five are latched error events, which software clears by writing 1.

Offset map: 0x00 configuration, 0x04 flow control (reads zero), 0x08 sample offset, 0x0C fine-tune (reads zero), 0x10 transmit data, 0x14 receive data, 0x18 queue status, 0x1C interrupt enable, 0x20 second enable (reads zero), 0x24 raw interrupt status with write-1-to-clear, 0x28 (reads zero), 0x2C masked interrupt status.

Top module: `wbu_uart`

## Requirements
- R1: After reset the configuration word reads 0, the sample offset reads 7, the status word at 0x18 reads 0xA, the raw status at 0x24 reads 0x20, serial_tx is high and irq is low.
- R2: The configuration word at 0x00 has these fields: bits [31:8] are the clocks per bit, bit 7 is the master enable, bit 5 is the transmit enable, bit 2 selects two stop bits, and bits [1:0] = L set 5+L data bits. When bits 7 and 5 are both set, each queued character goes out as a low start bit, the data bits LSB first, an optional parity bit and one or two high stop bits. Every bit lasts exactly the programmed number of clocks.
- R3: Configuration bit 4 enables a parity bit after the data bits. Bit 3 = 1 selects even parity (data bits plus parity hold an even number of ones) and bit 3 = 0 selects odd parity. The receiver checks parity with the same setting.
- R4: When configuration bits 7 and 6 are both set, the receiver samples every bit at the clock offset held in 0x08. Each received character is delivered in the low bits of 0x14, and unused upper bits read as zero.
- R5: A received parity bit that does not match sets raw status bit 2, and a low stop bit sets raw status bit 1. The character is still stored.
- R6: A falling edge on serial_rx that is high again at the sample offset is discarded as a glitch, and no character is stored.
- R7: The transmit queue holds 16 characters. Status bit 3 means transmit queue empty and bit 2 means transmit queue full. A write to 0x10 while the queue is full is dropped and sets raw status bit 0. Characters leave in write order.
- R8: A read of 0x14 while the receive queue is empty returns 0 and sets raw status bit 4.
- R9: The receive queue holds 16 characters. Status bit 1 means receive queue empty and bit 0 means receive queue full. A character arriving while the queue is full is dropped and sets raw status bit 3. Reads return characters in arrival order.
- R10: Raw status bit 6 is the live "receive queue not empty" level and bit 5 is the live "transmit queue empty" level; bits 4..0 are latched events. 0x2C reads raw status ANDed with the enable mask at 0x1C, and irq is high exactly when that value is nonzero. Writing 1 to a bit of 0x24 clears that latched event.
- R11: Offsets 0x04, 0x0C, 0x20 and 0x28 read as zero whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address of the word being accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read (pops the receive queue at 0x14) |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| serial_tx | output | 1 | Serial output, idles high |
| serial_rx | input | 1 | Serial input, asynchronous to clk |
| irq | output | 1 | Interrupt request, active high |

## Verification
Random characters are sent and received under random formats covering every data length, parity on and off, both parity senses and one or two stop bits. This separates errors in bit order, data masking, parity polarity and stop-bit count. Received frames are corrupted on purpose in the parity bit or in the first stop bit. This shows whether each error event is tied to the right bit position and whether the character is still stored. Directed runs fill each queue one past its depth, send a short low pulse as a false start bit, and read from an empty receive queue. These runs tell apart correct drop-and-flag behaviour from silent overwrite, and correct queue ordering from reordering.

// File: rtl/wbu_pkg.sv
// Shared definitions for the word-bus serial port.
// Assumes a 6-bit byte address with word-aligned accesses.
package wbu_pkg;
    localparam int REG_DW = 32;
    localparam int BAUD_W = 24;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CFG    = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_FLOW   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_SAMPLE = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_TUNE   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_TXD    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RXD    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_IEN0   = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_IEN1   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_IEV    = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_IEV1   = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_IST    = 6'h2C;

    // Configuration word, most significant field first.
    typedef struct packed {
        logic [BAUD_W-1:0] baud;
        logic              on;
        logic              rx_on;
        logic              tx_on;
        logic              par_on;
        logic              par_even;
        logic              stop2;
        logic [1:0]        len;
    } line_cfg_t;

    typedef enum logic [2:0] {PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP} phase_t;

    // Mask of the data bits in use for a length code (0 -> 5 bits).
    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction
endpackage

// File: rtl/wbu_fifo.sv
// Synchronous show-ahead queue. Assumes push is ignored when full and
// pop is ignored when empty; rdata shows the oldest entry.
module wbu_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full); // R9
endmodule

// File: rtl/wbu_tx.sv
// Serial transmitter. Takes characters from the show-ahead queue when idle
// and enabled. Assumes baud >= 2 and the format is stable during a frame.
module wbu_tx import wbu_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BAUD_W-1:0] baud,
    input  logic [1:0]        len,
    input  logic              par_on,
    input  logic              par_even,
    input  logic              stop2,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    output logic              fifo_pop,
    output logic              txd
);
    phase_t            ph;
    logic [BAUD_W-1:0] cnt;
    logic [7:0]        shreg, masked;
    logic [2:0]        idx, last_idx;
    logic              par_bit, stop_idx, bit_end;

    assign bit_end  = (cnt == baud - BAUD_W'(1));
    assign last_idx = 3'd4 + {1'b0, len};
    assign masked   = fifo_data & len_mask(len);
    assign fifo_pop = (ph == PH_IDLE) && go && !fifo_empty;

    // Frame sequencer: advances one bit every baud clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            idx      <= '0;
            par_bit  <= 1'b0;
            stop_idx <= 1'b0;
        end else if (ph == PH_IDLE) begin
            if (fifo_pop) begin
                ph      <= PH_START;
                cnt     <= '0;
                shreg   <= masked;
                par_bit <= par_even ? ^masked : ~^masked;
            end
        end else if (!bit_end) begin
            cnt <= cnt + BAUD_W'(1);
        end else begin
            cnt <= '0;
            case (ph)
                PH_START: begin
                    ph  <= PH_DATA;
                    idx <= '0;
                end
                PH_DATA: begin
                    shreg <= shreg >> 1;
                    if (idx == last_idx) begin
                        ph       <= par_on ? PH_PAR : PH_STOP;
                        stop_idx <= 1'b0;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
                PH_PAR: begin
                    ph       <= PH_STOP;
                    stop_idx <= 1'b0;
                end
                default: begin
                    if (stop_idx == stop2) ph <= PH_IDLE;
                    else                   stop_idx <= 1'b1;
                end
            endcase
        end
    end

    // Line level for the current phase.
    always_comb begin
        case (ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = shreg[0];
            PH_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    AST_START_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (txd == 1'b0)); // R2
endmodule

// File: rtl/wbu_rx.sv
// Serial receiver. Synchronises the line, detects a start edge, checks it
// at the sample offset and samples every later bit at that offset.
// Assumes sample_at < baud. Outputs are valid in the cycle push is high.
module wbu_rx import wbu_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BAUD_W-1:0] baud,
    input  logic [BAUD_W-1:0] sample_at,
    input  logic [1:0]        len,
    input  logic              par_on,
    input  logic              par_even,
    input  logic              stop2,
    input  logic              rxd_async,
    output logic              push,
    output logic [7:0]        data,
    output logic              par_err,
    output logic              stop_err
);
    logic [2:0]        sync;
    logic              line, fall, sample_now, bit_end, stop_idx;
    phase_t            ph;
    logic [BAUD_W-1:0] cnt;
    logic [2:0]        idx, last_idx;

    assign line       = sync[1];
    assign fall       = sync[2] && !sync[1];
    assign sample_now = (cnt == sample_at);
    assign bit_end    = (cnt == baud - BAUD_W'(1));
    assign last_idx   = 3'd4 + {1'b0, len};

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 3'b111;
        else        sync <= {sync[1:0], rxd_async};
    end

    // Frame sequencer and bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            idx      <= '0;
            stop_idx <= 1'b0;
            data     <= '0;
            par_err  <= 1'b0;
            stop_err <= 1'b0;
            push     <= 1'b0;
        end else begin
            push <= 1'b0;
            if (ph == PH_IDLE) begin
                if (go && fall) begin
                    ph       <= PH_START;
                    cnt      <= '0;
                    data     <= '0;
                    par_err  <= 1'b0;
                    stop_err <= 1'b0;
                end
            end else begin
                cnt <= bit_end ? '0 : cnt + BAUD_W'(1);
                case (ph)
                    PH_START: begin
                        if (sample_now && line) begin
                            ph <= PH_IDLE;
                        end else if (bit_end) begin
                            ph  <= PH_DATA;
                            idx <= '0;
                        end
                    end
                    PH_DATA: begin
                        if (sample_now) data[idx] <= line;
                        if (bit_end) begin
                            if (idx == last_idx) begin
                                ph       <= par_on ? PH_PAR : PH_STOP;
                                stop_idx <= 1'b0;
                            end else begin
                                idx <= idx + 3'd1;
                            end
                        end
                    end
                    PH_PAR: begin
                        if (sample_now)
                            par_err <= line != (par_even ? ^data : ~^data);
                        if (bit_end) begin
                            ph       <= PH_STOP;
                            stop_idx <= 1'b0;
                        end
                    end
                    default: begin
                        if (bit_end) stop_idx <= 1'b1;
                        if (sample_now) begin
                            if (!line) stop_err <= 1'b1;
                            if (stop_idx == stop2) begin
                                ph   <= PH_IDLE;
                                push <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end

    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_START && sample_now && line) |=> (ph == PH_IDLE && !push)); // R6
    AST_PUSH_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ($past(ph) == PH_STOP)); // R4
endmodule

// File: rtl/wbu_uart.sv
// Register front end of the serial port: configuration, sample offset,
// two queues, latched events and the interrupt line. Assumes one bus strobe
// per cycle; reads are combinational and a read of 0x14 pops the queue.
module wbu_uart import wbu_pkg::*; #(
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_DW-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [REG_DW-1:0] bus_rdata,
    output logic              serial_tx,
    input  logic              serial_rx,
    output logic              irq
);
    localparam int NEV = 5;
    localparam int NIRQ = NEV + 2;

    line_cfg_t         cfg_r;
    logic [BAUD_W-1:0] sample_r;
    logic [NIRQ-1:0]   ien_r, raw;
    logic [NEV-1:0]    ev_r, ev_set, ev_clr;
    logic              wr_txd, rd_rxd;
    logic              tx_full, tx_empty, tx_pop;
    logic [7:0]        tx_head;
    logic              rx_full, rx_empty, rx_push, rx_perr, rx_serr;
    logic [7:0]        rx_char, rx_head;

    assign wr_txd = bus_wr && (bus_addr == OFS_TXD);
    assign rd_rxd = bus_rd && (bus_addr == OFS_RXD);

    // Software-visible configuration, sample offset and enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_r    <= '0;
            sample_r <= BAUD_W'(7);
            ien_r    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CFG:    cfg_r    <= line_cfg_t'(bus_wdata);
                OFS_SAMPLE: sample_r <= bus_wdata[BAUD_W-1:0];
                OFS_IEN0:   ien_r    <= bus_wdata[NIRQ-1:0];
                default:    ;
            endcase
        end
    end

    wbu_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) tx_q (
        .clk(clk), .rst_n(rst_n), .push(wr_txd), .pop(tx_pop),
        .wdata(bus_wdata[7:0]), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
    );

    wbu_tx tx_i (
        .clk(clk), .rst_n(rst_n), .go(cfg_r.on && cfg_r.tx_on), .baud(cfg_r.baud),
        .len(cfg_r.len), .par_on(cfg_r.par_on), .par_even(cfg_r.par_even),
        .stop2(cfg_r.stop2), .fifo_empty(tx_empty), .fifo_data(tx_head),
        .fifo_pop(tx_pop), .txd(serial_tx)
    );

    wbu_rx rx_i (
        .clk(clk), .rst_n(rst_n), .go(cfg_r.on && cfg_r.rx_on), .baud(cfg_r.baud),
        .sample_at(sample_r), .len(cfg_r.len), .par_on(cfg_r.par_on),
        .par_even(cfg_r.par_even), .stop2(cfg_r.stop2), .rxd_async(serial_rx),
        .push(rx_push), .data(rx_char), .par_err(rx_perr), .stop_err(rx_serr)
    );

    wbu_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rx_q (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rd_rxd),
        .wdata(rx_char), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
    );

    // Event sources: underrun, overrun, parity, stop, transmit overrun.
    assign ev_set = {rd_rxd && rx_empty, rx_push && rx_full, rx_push && rx_perr,
                     rx_push && rx_serr, wr_txd && tx_full};
    assign ev_clr = (bus_wr && bus_addr == OFS_IEV) ? bus_wdata[NEV-1:0] : '0;

    // Latched events; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_r <= '0;
        else        ev_r <= (ev_r & ~ev_clr) | ev_set;
    end

    assign raw = {!rx_empty, tx_empty, ev_r};
    assign irq = |(raw & ien_r);

    // Read data selection.
    always_comb begin
        case (bus_addr)
            OFS_CFG:    bus_rdata = cfg_r;
            OFS_SAMPLE: bus_rdata = REG_DW'(sample_r);
            OFS_RXD:    bus_rdata = rx_empty ? '0 : REG_DW'(rx_head);
            OFS_STAT:   bus_rdata = REG_DW'({tx_empty, tx_full, rx_empty, rx_full});
            OFS_IEN0:   bus_rdata = REG_DW'(ien_r);
            OFS_IEV:    bus_rdata = REG_DW'(raw);
            OFS_IST:    bus_rdata = REG_DW'(raw & ien_r);
            default:    bus_rdata = '0;
        endcase
    end

    AST_TXOVR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && tx_full) |=> bus_rd || ev_r[0] || (bus_wr && bus_addr == OFS_IEV)); // R7
    AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |-> (bus_rdata == '0)); // R8
    AST_UNDERRUN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty && !(bus_wr && bus_addr == OFS_IEV)) |=> ev_r[4]); // R8
    AST_OVERRUN_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !bus_wr) |=> ev_r[3]); // R9
endmodule

// File: tb/wbu_uart_tb_top.sv
`timescale 1ns/1ps
module wbu_uart_tb_top;
    import wbu_pkg::*;

    localparam int BC = 16;
    localparam int SP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        serial_tx;
    logic        serial_rx = 1'b1;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wbu_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .serial_tx(serial_tx), .serial_rx(serial_rx), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cfg_word(input logic tx, input logic rx, input logic pe,
                                             input logic ev, input logic s2, input logic [1:0] len);
        return {24'(BC), 1'b1, rx, tx, pe, ev, s2, len};
    endfunction

    function automatic logic [7:0] dmask(input logic [1:0] len);
        return 8'((9'd1 << (5 + len)) - 9'd1);
    endfunction

    function automatic int flen(input logic pe, input logic s2, input logic [1:0] len);
        return 7 + int'(len) + int'(pe) + int'(s2);
    endfunction

    // Expected line bits, first bit in position 0.
    function automatic logic [11:0] frame(input logic [7:0] d, input logic pe, input logic ev,
                                          input logic s2, input logic [1:0] len);
        logic [11:0] f = '1;
        logic [7:0]  m = d & dmask(len);
        int k = 1;
        f[0] = 1'b0;
        for (int i = 0; i < 5 + int'(len); i++) begin f[k] = m[i]; k++; end
        if (pe) f[k] = ev ? ^m : ~^m;
        return f;
    endfunction

    task automatic grab_tx(input int nb, output logic [11:0] got);
        int t = 0;
        got = '1;
        while (serial_tx !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
        repeat (BC / 2) @(negedge clk);
        got[0] = serial_tx;
        for (int i = 1; i < nb; i++) begin
            repeat (BC) @(negedge clk);
            got[i] = serial_tx;
        end
    endtask

    task automatic send_rx(input logic [7:0] d, input logic pe, input logic ev, input logic s2,
                           input logic [1:0] len, input logic bad_par, input logic bad_stop);
        logic [11:0] f = frame(d, pe, ev, s2, len);
        int n = flen(pe, s2, len);
        if (bad_par) f[6 + len] = ~f[6 + len];
        if (bad_stop) f[6 + int'(len) + int'(pe)] = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            serial_rx = f[i];
            repeat (BC - 1) @(negedge clk);
        end
        @(negedge clk);
        serial_rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [11:0] got;
        void'($urandom(32'd7321));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(OFS_STAT, v);   check("R1 status", v, 32'hA);
        rd(OFS_CFG, v);    check("R1 config", v, 32'h0);
        rd(OFS_SAMPLE, v); check("R1 sample", v, 32'd7);
        rd(OFS_IEV, v);    check("R1 raw", v, 32'h20);
        check("R1 serial_tx", 32'(serial_tx), 32'd1);
        check("R1 irq", 32'(irq), 32'd0);

        // R11 zero-reading offsets
        wr(OFS_FLOW, 32'hFFFF_FFFF); rd(OFS_FLOW, v); check("R11 flow", v, 0);
        wr(OFS_TUNE, 32'hFFFF_FFFF); rd(OFS_TUNE, v); check("R11 tune", v, 0);
        wr(OFS_IEN1, 32'h7F);        rd(OFS_IEN1, v); check("R11 en1", v, 0);
        wr(OFS_IEV1, 32'h7F);        rd(OFS_IEV1, v); check("R11 ev1", v, 0);

        wr(OFS_SAMPLE, SP); rd(OFS_SAMPLE, v); check("R4 sample reg", v, SP);

        // R10 level source and masking
        wr(OFS_IEN0, 32'h20); check("R10 irq on tx empty", 32'(irq), 1);
        rd(OFS_IST, v);       check("R10 masked status", v, 32'h20);
        wr(OFS_IEN0, 32'h0);  check("R10 irq masked", 32'(irq), 0);

        // R8 underrun
        rd(OFS_RXD, v); check("R8 empty read", v, 0);
        rd(OFS_IEV, v); check("R8 underrun flag", v, 32'h30);
        wr(OFS_IEN0, 32'h10); check("R10 irq on underrun", 32'(irq), 1);
        wr(OFS_IEV, 32'h10);  check("R10 irq after clear", 32'(irq), 0);
        rd(OFS_IEV, v);       check("R10 cleared", v, 32'h20);
        wr(OFS_IEN0, 32'h0);

        // R2 R3 R4 R5 random formats
        for (int it = 0; it < 30; it++) begin
            logic [1:0] len = 2'($urandom % 4);
            logic pe = 1'($urandom % 2);
            logic ev = 1'($urandom % 2);
            logic s2 = 1'($urandom % 2);
            logic [7:0] d = 8'($urandom);
            int kind = int'($urandom % 4);
            logic bp = pe && (kind == 2);
            logic bs = (kind == 3);
            wr(OFS_CFG, cfg_word(1'b1, 1'b1, pe, ev, s2, len));
            wr(OFS_TXD, {24'h0, d});
            grab_tx(flen(pe, s2, len), got);
            check("R2 R3 tx frame", 32'(got), 32'(frame(d, pe, ev, s2, len)));
            send_rx(d, pe, ev, s2, len, bp, bs);
            rd(OFS_IEV, v);
            check("R5 R10 raw after rx", v, 32'h60 | (32'(bp) << 2) | (32'(bs) << 1));
            rd(OFS_RXD, v); check("R4 rx data", v, 32'(d & dmask(len)));
            rd(OFS_STAT, v); check("R4 rx drained", v, 32'hA);
            wr(OFS_IEV, 32'h1F);
        end

        // R6 glitch rejection
        wr(OFS_CFG, cfg_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3));
        @(negedge clk); serial_rx = 1'b0;
        repeat (3) @(negedge clk); serial_rx = 1'b1;
        repeat (3 * BC) @(negedge clk);
        rd(OFS_STAT, v); check("R6 no char after glitch", v, 32'hA);
        rd(OFS_IEV, v);  check("R6 no event after glitch", v, 32'h20);

        // R7 transmit queue overflow and order
        wr(OFS_CFG, cfg_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3));
        for (int i = 0; i < 17; i++) wr(OFS_TXD, 32'h40 + i);
        rd(OFS_STAT, v); check("R7 tx full", v, 32'h6);
        rd(OFS_IEV, v);  check("R7 tx overrun", v, 32'h01);
        check("R7 line idle while disabled", 32'(serial_tx), 1);
        wr(OFS_CFG, cfg_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3));
        for (int i = 0; i < 16; i++) begin
            grab_tx(10, got);
            check("R7 tx order", 32'(got), 32'(frame(8'(8'h40 + i), 1'b0, 1'b0, 1'b0, 2'd3)));
        end
        repeat (BC) @(negedge clk);
        rd(OFS_STAT, v); check("R7 tx drained", v, 32'hA);
        wr(OFS_IEV, 32'h1F);

        // R9 receive queue overflow and order
        for (int i = 0; i < 17; i++)
            send_rx(8'(8'h80 + i), 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0);
        rd(OFS_STAT, v); check("R9 rx full", v, 32'h9);
        rd(OFS_IEV, v);  check("R9 rx overrun", v, 32'h68);
        wr(OFS_IEN0, 32'h08); check("R10 irq on overrun", 32'(irq), 1);
        rd(OFS_IST, v);       check("R10 masked overrun", v, 32'h08);
        for (int i = 0; i < 16; i++) begin
            rd(OFS_RXD, v); check("R9 rx order", v, 32'h80 + i);
        end
        rd(OFS_RXD, v); check("R8 empty read after drain", v, 0);
        rd(OFS_IEV, v); check("R8 underrun after drain", v, 32'h38);
        wr(OFS_IEV, 32'h1F);
        rd(OFS_IEV, v); check("R10 all cleared", v, 32'h20);
        check("R10 irq low", 32'(irq), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule